// File: doc/BRIEF.md
# Programmable Pad Cell Controller

This block holds the digital control for one user pad of a programmable logic device. Static configuration inputs choose where the output-enable comes from, whether the pad acts as an open-drain output, and whether a register sits on the input path, the output path, or both. The array side supplies the output data and two local-bus enable controls. The block returns the value seen at the pad to the array, either directly or through a register.

At power-up the pad is held as a non-driving input. Only the weak pull that is configured for it is on. The output register is loaded with a chosen level. The core-supply-good indication is synchronised, and a counter releases the pulls and the output a fixed number of clock cycles after that indication rises. If supply-good falls, the hold state returns. An external power-on reset forces the hold state at once.

Top module: `pad_cell_ctrl`

## Requirements
- R1: `cfg_oe_sel` selects the enable control, which is active low. Code 0: the pad always drives. Code 1: the pad never drives. Code 2: the pad drives while `vbus_oe_n` is 0. Code 3: the pad drives while `hbus_oe_n` is 0. The bus that is not selected has no effect.
- R2: With `cfg_open_drain` = 1, a data value of 1 leaves `pad_oe` = 0, and a data value of 0 drives the pad low (`pad_oe` = 1, `pad_out` = 0). `pad_out` is never 1 in this mode.
- R3: While the hold state lasts, `pad_oe` = 0 and `pad_out` = 0. Outside it, `pad_out` equals the data whenever `pad_oe` = 1, and is 0 whenever `pad_oe` = 0.
- R4: During hold, `pull_up_en` = `cfg_pull_up` and `pull_dn_en` = `cfg_pull_dn` AND NOT `cfg_pull_up`, so the pull-up wins when both are set. With neither set, both enables are 0. Both enables are 0 outside hold.
- R5: The hold state ends exactly SYNC_STAGES + RELEASE_CYCLES rising clock edges after the first edge that samples `core_good_i` = 1. With the defaults (2 and 3), the pulls are still on after edge 4 and off after edge 5.
- R6: If `core_good_i` is sampled low, the hold state returns after SYNC_STAGES + 1 edges, and the release count restarts from zero.
- R7: `por_i` = 1 forces the hold state asynchronously. The outputs show hold values in the same cycle.
- R8: With `cfg_out_reg` = 1, the pad drives `cfg_init_high` in the first cycle after release, whatever `arr_dout` is. The output register follows `arr_dout` from the next edge on.
- R9: With `cfg_in_reg` = 1, `arr_din` shows the pad value sampled at the previous rising edge. With `cfg_in_reg` = 0, `arr_din` follows the pad value in the same cycle.
- R10: With `cfg_out_reg` = 1, the output enable and the output data are taken from registers loaded on the same edge. A change of `cfg_oe_sel` or `arr_dout` reaches `pad_oe` and `pad_out` together, one edge later.
- R11: The pad value fed back to the input path is `pad_out` while `pad_oe` = 1, and `pad_in` (the external level) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| por_i | input | 1 | External power-on reset, active high, asynchronous |
| core_good_i | input | 1 | Core supply good, asynchronous |
| cfg_oe_sel | input | 2 | Enable source code (see R1) |
| cfg_open_drain | input | 1 | Open-drain mode |
| cfg_in_reg | input | 1 | Register the input path |
| cfg_out_reg | input | 1 | Register the output data and enable |
| cfg_pull_up | input | 1 | Pull-up wanted during hold |
| cfg_pull_dn | input | 1 | Pull-down wanted during hold |
| cfg_init_high | input | 1 | Output register level at release |
| arr_dout | input | 1 | Output data from the array |
| vbus_oe_n | input | 1 | Vertical local bus enable, active low |
| hbus_oe_n | input | 1 | Horizontal local bus enable, active low |
| pad_in | input | 1 | External pad level |
| pad_out | output | 1 | Value driven onto the pad |
| pad_oe | output | 1 | Pad output driver enable |
| pull_up_en | output | 1 | Weak pull-up enable |
| pull_dn_en | output | 1 | Weak pull-down enable |
| arr_din | output | 1 | Pad value returned to the array |

## Verification
Two things are hard to reach from the ports. One is the exact edge at which the pulls release. The other is the level the output register holds in that first released cycle. The stimulus raises `core_good_i` with the output register enabled and `arr_dout` set opposite to `cfg_init_high`. It then checks every cycle from the sampling edge to one cycle past the release, once for each initial level. Re-arming is reached by dropping supply-good while the pad is driving, with both pulls configured. The checks then show that the hold state returns on the predicted edge and that the pull-up wins.

// File: rtl/pad_cell_pkg.sv
package pad_cell_pkg;

    typedef enum logic [1:0] {
        OE_ALWAYS = 2'd0,
        OE_NEVER  = 2'd1,
        OE_VBUS   = 2'd2,
        OE_HBUS   = 2'd3
    } oe_src_e;

    typedef struct packed {
        logic oe;
        logic data;
        logic din;
    } io_regs_t;

endpackage

// File: rtl/pad_pwr_seq.sv
module pad_pwr_seq #(
    parameter int SYNC_STAGES    = 2,
    parameter int RELEASE_CYCLES = 3
) (
    input  logic clk,
    input  logic por_i,
    input  logic core_good_i,
    input  logic cfg_pull_up,
    input  logic cfg_pull_dn,
    output logic hold,
    output logic pull_up_en,
    output logic pull_dn_en
);
    localparam int CW = $clog2(RELEASE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   hold;
    } seq_t;

    seq_t st_d, st_q;
    logic good_s;

    assign good_s = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], core_good_i};
        if (!good_s) begin
            st_d.cnt  = '0;
            st_d.hold = 1'b1;
        end else if (st_q.hold) begin
            if (st_q.cnt == LAST) begin
                st_d.hold = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            st_q <= '{sync: '0, cnt: '0, hold: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // pull-up has priority over pull-down
    assign hold       = st_q.hold;
    assign pull_up_en = st_q.hold & cfg_pull_up;
    assign pull_dn_en = st_q.hold & cfg_pull_dn & ~cfg_pull_up;

endmodule

// File: rtl/pad_oe_mux.sv
module pad_oe_mux
    import pad_cell_pkg::*;
(
    input  logic [1:0] cfg_oe_sel,
    input  logic       vbus_oe_n,
    input  logic       hbus_oe_n,
    output logic       oe_req
);
    logic ctrl_n;

    always_comb begin
        unique case (oe_src_e'(cfg_oe_sel))
            OE_ALWAYS: ctrl_n = 1'b0;
            OE_NEVER:  ctrl_n = 1'b1;
            OE_VBUS:   ctrl_n = vbus_oe_n;
            OE_HBUS:   ctrl_n = hbus_oe_n;
            default:   ctrl_n = 1'b1;
        endcase
    end

    assign oe_req = ~ctrl_n;

endmodule

// File: rtl/pad_data_path.sv
module pad_data_path
    import pad_cell_pkg::*;
(
    input  logic clk,
    input  logic por_i,
    input  logic hold,
    input  logic cfg_in_reg,
    input  logic cfg_out_reg,
    input  logic cfg_open_drain,
    input  logic cfg_init_high,
    input  logic oe_req,
    input  logic arr_dout,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_val,
    output logic arr_din
);
    io_regs_t r_d, r_q;
    logic oe_path, data_path, drive;

    // enable and data sit in one register bank: they move on the same edge
    always_comb begin
        r_d      = r_q;
        r_d.oe   = oe_req;
        r_d.data = hold ? cfg_init_high : arr_dout;
        r_d.din  = pad_val;
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign oe_path   = cfg_out_reg ? r_q.oe   : oe_req;
    assign data_path = cfg_out_reg ? r_q.data : arr_dout;
    assign drive     = ~hold & oe_path & (~cfg_open_drain | ~data_path);
    assign pad_oe    = drive;
    assign pad_out   = drive & data_path;
    assign pad_val   = drive ? pad_out : pad_in;
    assign arr_din   = cfg_in_reg ? r_q.din : pad_val;

endmodule

// File: rtl/pad_cell_ctrl.sv
module pad_cell_ctrl #(
    parameter int SYNC_STAGES    = 2,
    parameter int RELEASE_CYCLES = 3
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       core_good_i,
    input  logic [1:0] cfg_oe_sel,
    input  logic       cfg_open_drain,
    input  logic       cfg_in_reg,
    input  logic       cfg_out_reg,
    input  logic       cfg_pull_up,
    input  logic       cfg_pull_dn,
    input  logic       cfg_init_high,
    input  logic       arr_dout,
    input  logic       vbus_oe_n,
    input  logic       hbus_oe_n,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pull_up_en,
    output logic       pull_dn_en,
    output logic       arr_din
);
    logic hold;
    logic oe_req;
    logic pad_val;

    pad_pwr_seq #(
        .SYNC_STAGES   (SYNC_STAGES),
        .RELEASE_CYCLES(RELEASE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .por_i      (por_i),
        .core_good_i(core_good_i),
        .cfg_pull_up(cfg_pull_up),
        .cfg_pull_dn(cfg_pull_dn),
        .hold       (hold),
        .pull_up_en (pull_up_en),
        .pull_dn_en (pull_dn_en)
    );

    pad_oe_mux u_mux (
        .cfg_oe_sel(cfg_oe_sel),
        .vbus_oe_n (vbus_oe_n),
        .hbus_oe_n (hbus_oe_n),
        .oe_req    (oe_req)
    );

    pad_data_path u_path (
        .clk           (clk),
        .por_i         (por_i),
        .hold          (hold),
        .cfg_in_reg    (cfg_in_reg),
        .cfg_out_reg   (cfg_out_reg),
        .cfg_open_drain(cfg_open_drain),
        .cfg_init_high (cfg_init_high),
        .oe_req        (oe_req),
        .arr_dout      (arr_dout),
        .pad_in        (pad_in),
        .pad_out       (pad_out),
        .pad_oe        (pad_oe),
        .pad_val       (pad_val),
        .arr_din       (arr_din)
    );

endmodule

// File: rtl/pad_cell_ctrl_chk.sv
module pad_cell_ctrl_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic por_i,
    input logic core_good_i,
    input logic cfg_open_drain,
    input logic cfg_in_reg,
    input logic hold,
    input logic pad_val,
    input logic pad_out,
    input logic pad_oe,
    input logic pull_up_en,
    input logic pull_dn_en,
    input logic arr_din
);
    localparam int LW = $clog2(SYNC_STAGES + 2);
    localparam logic [LW-1:0] LMAX = LW'(SYNC_STAGES + 1);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            low_cnt <= '0;
        end else if (core_good_i) begin
            low_cnt <= '0;
        end else if (low_cnt != LMAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R4
    pull_excl_chk: assert property (@(posedge clk) disable iff (por_i)
        !(pull_up_en && pull_dn_en));

    // R3
    hold_no_drive_chk: assert property (@(posedge clk) disable iff (por_i)
        (pull_up_en || pull_dn_en) |-> !pad_oe);

    // R2
    od_never_high_chk: assert property (@(posedge clk) disable iff (por_i)
        cfg_open_drain |-> !pad_out);

    // R6
    rearm_chk: assert property (@(posedge clk) disable iff (por_i)
        (low_cnt == LMAX) |-> hold);

    // R9
    in_reg_chk: assert property (@(posedge clk) disable iff (por_i)
        (cfg_in_reg && $past(cfg_in_reg) && !$past(por_i)) |-> (arr_din == $past(pad_val)));

endmodule

bind pad_cell_ctrl pad_cell_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk           (clk),
    .por_i         (por_i),
    .core_good_i   (core_good_i),
    .cfg_open_drain(cfg_open_drain),
    .cfg_in_reg    (cfg_in_reg),
    .hold          (hold),
    .pad_val       (pad_val),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .pull_up_en    (pull_up_en),
    .pull_dn_en    (pull_dn_en),
    .arr_din       (arr_din)
);

// File: tb/sim_pad_cell_ctrl.sv
`timescale 1ns/1ps
module sim_pad_cell_ctrl;

    logic clk = 1'b0;
    logic por_i, core_good_i;
    logic [1:0] cfg_oe_sel;
    logic cfg_open_drain, cfg_in_reg, cfg_out_reg;
    logic cfg_pull_up, cfg_pull_dn, cfg_init_high;
    logic arr_dout, vbus_oe_n, hbus_oe_n, pad_in;
    logic pad_out, pad_oe, pull_up_en, pull_dn_en, arr_din;

    always #10 clk = ~clk;

    pad_cell_ctrl u0 (
        .clk(clk), .por_i(por_i), .core_good_i(core_good_i),
        .cfg_oe_sel(cfg_oe_sel), .cfg_open_drain(cfg_open_drain),
        .cfg_in_reg(cfg_in_reg), .cfg_out_reg(cfg_out_reg),
        .cfg_pull_up(cfg_pull_up), .cfg_pull_dn(cfg_pull_dn),
        .cfg_init_high(cfg_init_high), .arr_dout(arr_dout),
        .vbus_oe_n(vbus_oe_n), .hbus_oe_n(hbus_oe_n), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_up_en(pull_up_en),
        .pull_dn_en(pull_dn_en), .arr_din(arr_din)
    );

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [4:0] act;
            it  = sb.pop_front();
            act = {pad_out, pad_oe, pull_up_en, pull_dn_en, arr_din};
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: {out,oe,pu,pd,din} actual %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic tick_chk(input logic po, input logic poe, input logic pu,
                            input logic pd, input logic din, input string tag);
        item_t it;
        it.exp = {po, poe, pu, pd, din};
        it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        por_i = 1'b1; core_good_i = 1'b0;
        cfg_oe_sel = 2'd0; cfg_open_drain = 1'b0; cfg_in_reg = 1'b0;
        cfg_out_reg = 1'b1; cfg_pull_up = 1'b1; cfg_pull_dn = 1'b0;
        cfg_init_high = 1'b1; arr_dout = 1'b0; vbus_oe_n = 1'b1;
        hbus_oe_n = 1'b1; pad_in = 1'b1;
        tick();
        tick_chk(0, 0, 1, 0, 1, "R3 reset");
        tick_chk(0, 0, 1, 0, 1, "R4 pull-up in hold");
        por_i = 1'b0;
        tick_chk(0, 0, 1, 0, 1, "R3 hold without supply");
        pad_in = 1'b0;
        tick_chk(0, 0, 1, 0, 0, "R11 pad_in fed back in hold");

        // release: edges counted from the first sampling edge
        core_good_i = 1'b1;
        tick();
        for (int k = 1; k <= 4; k++) tick_chk(0, 0, 1, 0, 0, "R5 still held");
        tick_chk(1, 1, 0, 0, 1, "R8 init high at release");
        tick_chk(0, 1, 0, 0, 0, "R10 data follows after release");

        // combinational output path
        cfg_out_reg = 1'b0;
        tick_chk(0, 1, 0, 0, 0, "R1 code0 drives");
        arr_dout = 1'b1;
        tick_chk(1, 1, 0, 0, 1, "R11 driven value fed back");
        cfg_oe_sel = 2'd1;
        tick_chk(0, 0, 0, 0, 0, "R1 code1 never drives");
        pad_in = 1'b1;
        tick_chk(0, 0, 0, 0, 1, "R11 external level fed back");
        cfg_oe_sel = 2'd2; vbus_oe_n = 1'b0;
        tick_chk(1, 1, 0, 0, 1, "R1 code2 vbus low drives");
        vbus_oe_n = 1'b1; hbus_oe_n = 1'b0;
        tick_chk(0, 0, 0, 0, 1, "R1 code2 hbus ignored");
        cfg_oe_sel = 2'd3;
        tick_chk(1, 1, 0, 0, 1, "R1 code3 hbus low drives");
        hbus_oe_n = 1'b1; vbus_oe_n = 1'b0;
        tick_chk(0, 0, 0, 0, 1, "R1 code3 vbus ignored");
        vbus_oe_n = 1'b1;

        // open drain
        cfg_oe_sel = 2'd0; cfg_open_drain = 1'b1; arr_dout = 1'b1;
        tick_chk(0, 0, 0, 0, 1, "R2 one tristates");
        arr_dout = 1'b0;
        tick_chk(0, 1, 0, 0, 0, "R2 zero driven");
        cfg_open_drain = 1'b0;

        // input register
        cfg_oe_sel = 2'd1; pad_in = 1'b1;
        tick_chk(0, 0, 0, 0, 1, "R9 direct input");
        cfg_in_reg = 1'b1; pad_in = 1'b0;
        tick_chk(0, 0, 0, 0, 1, "R9 registered holds old");
        tick_chk(0, 0, 0, 0, 0, "R9 registered updates");

        // output register
        cfg_in_reg = 1'b0; cfg_out_reg = 1'b1;
        tick_chk(0, 0, 0, 0, 0, "R10 registered idle");
        cfg_oe_sel = 2'd0; arr_dout = 1'b1;
        tick_chk(0, 0, 0, 0, 0, "R10 oe and data wait an edge");
        tick_chk(1, 1, 0, 0, 1, "R10 oe and data together");
        cfg_oe_sel = 2'd1; arr_dout = 1'b0;
        tick_chk(1, 1, 0, 0, 1, "R10 old values held");
        tick_chk(0, 0, 0, 0, 0, "R10 both released together");

        // supply drop re-arms the hold; both pulls configured
        cfg_pull_up = 1'b1; cfg_pull_dn = 1'b1;
        cfg_oe_sel = 2'd0; arr_dout = 1'b1;
        tick();
        tick_chk(1, 1, 0, 0, 1, "R6 driving before drop");
        core_good_i = 1'b0;
        tick();
        tick();
        tick_chk(1, 1, 0, 0, 1, "R6 not yet re-armed");
        tick_chk(0, 0, 1, 0, 0, "R4 R6 re-armed pull-up wins");
        cfg_pull_up = 1'b0;
        tick_chk(0, 0, 0, 1, 0, "R4 pull-down only");
        cfg_pull_dn = 1'b0;
        tick_chk(0, 0, 0, 0, 0, "R4 no pull tristate");

        // release with low init level
        cfg_init_high = 1'b0; pad_in = 1'b1;
        core_good_i = 1'b1;
        tick();
        for (int k = 1; k <= 4; k++) tick_chk(0, 0, 0, 0, 1, "R5 held after restart");
        tick_chk(0, 1, 0, 0, 0, "R8 init low at release");
        tick_chk(1, 1, 0, 0, 1, "R8 follows data afterwards");

        // asynchronous power-on reset
        cfg_pull_up = 1'b1;
        por_i = 1'b1;
        tick_chk(0, 0, 1, 0, 1, "R7 por forces hold at once");
        por_i = 1'b0;
        tick_chk(0, 0, 1, 0, 1, "R7 hold persists after por");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule